// File: doc/BRIEF.md
# Multithreaded Issue Thread Selector

This block decides, every cycle, which hardware thread of a multithreaded core may issue an instruction. Each thread keeps its own program counter inside the block. The block takes per-thread ready and short-stall flags, a long-latency miss event for the issuing thread, and per-thread miss-complete flags. From these it drives the chosen thread index, an issue-valid flag, a switch flag and the program counter of the chosen thread.

A mode input picks one of two policies. In fine-grain mode the selector rotates to a different thread on every cycle and passes over threads that cannot issue. In coarse-grain mode it stays on one thread through short stalls and moves on only when that thread takes a long miss. Each coarse move costs a fixed number of dead cycles. A thread that took a long miss is parked until its miss-complete flag arrives.

Top module: `mt_issue_sel`

## Requirements
- R1: After reset the current thread is 0, the last-issued thread is NUM_THREADS-1, no thread is parked, and every program counter equals BOOT_PC.
- R2: In fine-grain mode (mode_i=0) the selected thread is the first eligible thread found by searching upward from the last-issued thread plus one, wrapping around. switch_o is 1 when an issue goes to a thread other than the current one. A thread is eligible when ready_i is 1, stall_i is 0 and it is not parked.
- R3: In fine-grain mode a thread with stall_i=1 or ready_i=0 is never selected while another thread is eligible.
- R4: issue_o is 0 in any cycle in which the selected thread is not eligible. In fine-grain mode this means no thread is eligible.
- R5: In coarse-grain mode (mode_i=1) tid_o holds the current thread until a switch. A short stall on that thread lowers issue_o but causes no switch.
- R6: In coarse-grain mode, miss_i with issue_o parks the current thread. In the same cycle switch_o rises, and the next current thread is the first unparked thread after the old one, wrapping around.
- R7: After a coarse switch, issue_o stays 0 for SWITCH_BUBBLES cycles (2 by default).
- R8: A parked thread cannot issue. Its miss_done_i bit unparks it from the next cycle on. If the current coarse thread is parked and another thread becomes unparked, the selector switches to it.
- R9: If a coarse miss leaves no other unparked thread, no switch occurs and the selector waits on the current thread.
- R10: pc_o is the program counter of thread tid_o. When issue_o and adv_i are both 1, that counter advances by INSTR_BYTES. Otherwise it holds.
- R11: redir_i loads redir_pc_i into the counter of thread redir_tid_i. This takes priority over an advance of the same thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 fine-grain, 1 coarse-grain |
| ready_i | input | NUM_THREADS | Thread has an instruction available |
| stall_i | input | NUM_THREADS | Thread has a short stall (hazard) |
| miss_i | input | 1 | Issuing thread took a long-latency miss |
| miss_done_i | input | NUM_THREADS | Long miss of a thread has completed |
| adv_i | input | 1 | Advance the PC of the issuing thread |
| redir_i | input | 1 | Load a new PC into one thread |
| redir_tid_i | input | TID_W | Thread that receives the redirect |
| redir_pc_i | input | PC_W | Redirect target |
| tid_o | output | TID_W | Selected thread |
| issue_o | output | 1 | Selected thread issues this cycle |
| switch_o | output | 1 | Selection moves to another thread |
| pc_o | output | PC_W | PC of the selected thread |

## Verification
The assertions assume that miss_i is meaningful only while issue_o is high, and that ready_i and stall_i reflect the threads' true state in every cycle. The stimulus follows these assumptions: it raises miss_i only in cycles where the expected result has an issue, and it changes mode_i only across a reset. It drives all inputs half a cycle before the sampling edge, so each combinational output is settled when the bench checks it.

// File: rtl/mt_sel_pkg.sv
package mt_sel_pkg;
  typedef enum logic {
    MODE_FINE   = 1'b0,
    MODE_COARSE = 1'b1
  } sel_mode_e;
endpackage

// File: rtl/mt_rr_pick.sv
// First set request strictly after base_i, wrapping (base_i itself is last).
module mt_rr_pick #(
  parameter int N = 4,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] req_i,
  input  logic [W-1:0] base_i,
  output logic         found_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = base_i;
    for (int k = N - 1; k >= 0; k--) begin
      automatic int j = (int'(base_i) + 1 + k) % N;
      if (req_i[j]) begin
        found_o = 1'b1;
        idx_o   = W'(j);
      end
    end
  end
endmodule

// File: rtl/mt_park_set.sv
module mt_park_set #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] parked_o,
  output logic [N-1:0] parked_nxt_o
);
  logic [N-1:0] parked_q;

  // a new miss beats a completion in the same cycle
  assign parked_nxt_o = (parked_q & ~clr_i) | set_i;
  assign parked_o     = parked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) parked_q <= '0;
    else         parked_q <= parked_nxt_o;
  end
endmodule

// File: rtl/mt_pc_bank.sv
module mt_pc_bank #(
  parameter int          N       = 4,
  parameter int          PC_W    = 32,
  parameter int          STEP    = 4,
  parameter logic [31:0] BOOT_PC = 32'h0,
  localparam int         W       = $clog2(N)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            adv_en_i,
  input  logic [W-1:0]    adv_tid_i,
  input  logic            redir_i,
  input  logic [W-1:0]    redir_tid_i,
  input  logic [PC_W-1:0] redir_pc_i,
  input  logic [W-1:0]    rd_tid_i,
  output logic [PC_W-1:0] pc_o
);
  logic [PC_W-1:0] pc_q [N];

  for (genvar g = 0; g < N; g++) begin : g_pc
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        pc_q[g] <= PC_W'(BOOT_PC);
      else if (redir_i && redir_tid_i == W'(g))
        pc_q[g] <= redir_pc_i;
      else if (adv_en_i && adv_tid_i == W'(g))
        pc_q[g] <= pc_q[g] + PC_W'(STEP);
    end
  end

  assign pc_o = pc_q[rd_tid_i];
endmodule

// File: rtl/mt_issue_sel.sv
module mt_issue_sel
  import mt_sel_pkg::*;
#(
  parameter int          NUM_THREADS    = 4,
  parameter int          PC_W           = 32,
  parameter int          INSTR_BYTES    = 4,
  parameter int          SWITCH_BUBBLES = 2,
  parameter logic [31:0] BOOT_PC        = 32'h0,
  localparam int         TID_W          = $clog2(NUM_THREADS),
  localparam int         BUB_W          = $clog2(SWITCH_BUBBLES + 2)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   mode_i,
  input  logic [NUM_THREADS-1:0] ready_i,
  input  logic [NUM_THREADS-1:0] stall_i,
  input  logic                   miss_i,
  input  logic [NUM_THREADS-1:0] miss_done_i,
  input  logic                   adv_i,
  input  logic                   redir_i,
  input  logic [TID_W-1:0]       redir_tid_i,
  input  logic [PC_W-1:0]        redir_pc_i,
  output logic [TID_W-1:0]       tid_o,
  output logic                   issue_o,
  output logic                   switch_o,
  output logic [PC_W-1:0]        pc_o
);
  logic [TID_W-1:0]       cur_q, last_q;
  logic [BUB_W-1:0]       bub_q;
  logic [NUM_THREADS-1:0] parked, parked_nxt, elig, miss_set, cur_oh, sw_req;
  logic                   coarse, no_bub, f_found, s_found, sw_go;
  logic [TID_W-1:0]       f_idx, s_idx;

  assign coarse = (sel_mode_e'(mode_i) == MODE_COARSE);
  assign no_bub = (bub_q == '0);
  assign elig   = ready_i & ~stall_i & ~parked;

  always_comb begin
    cur_oh        = '0;
    cur_oh[cur_q] = 1'b1;
  end

  mt_rr_pick #(.N(NUM_THREADS), .W(TID_W)) u_fine_pick (
    .req_i   (elig),
    .base_i  (last_q),
    .found_o (f_found),
    .idx_o   (f_idx)
  );

  always_comb begin
    if (coarse) begin
      tid_o   = cur_q;
      issue_o = elig[cur_q] & no_bub;
    end else begin
      tid_o   = f_found ? f_idx : cur_q;
      issue_o = f_found & no_bub;
    end
  end

  always_comb begin
    miss_set = '0;
    if (issue_o && miss_i) miss_set[tid_o] = 1'b1;
  end

  mt_park_set #(.N(NUM_THREADS)) u_park (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .set_i        (miss_set),
    .clr_i        (miss_done_i),
    .parked_o     (parked),
    .parked_nxt_o (parked_nxt)
  );

  assign sw_req = ~parked_nxt & ~cur_oh;

  mt_rr_pick #(.N(NUM_THREADS), .W(TID_W)) u_sw_pick (
    .req_i   (sw_req),
    .base_i  (cur_q),
    .found_o (s_found),
    .idx_o   (s_idx)
  );

  // coarse switch: current thread is (or is becoming) parked and another is free
  assign sw_go    = coarse & no_bub & parked_nxt[cur_q] & s_found;
  assign switch_o = coarse ? sw_go : (issue_o && tid_o != cur_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      last_q <= TID_W'(NUM_THREADS - 1);
      bub_q  <= '0;
    end else begin
      if (issue_o) last_q <= tid_o;
      if (coarse && sw_go) begin
        cur_q <= s_idx;
        bub_q <= BUB_W'(SWITCH_BUBBLES);
      end else begin
        if (!coarse && issue_o) cur_q <= tid_o;
        if (!no_bub) bub_q <= bub_q - 1'b1;
      end
    end
  end

  mt_pc_bank #(
    .N(NUM_THREADS), .PC_W(PC_W), .STEP(INSTR_BYTES), .BOOT_PC(BOOT_PC)
  ) u_pc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .adv_en_i    (issue_o & adv_i),
    .adv_tid_i   (tid_o),
    .redir_i     (redir_i),
    .redir_tid_i (redir_tid_i),
    .redir_pc_i  (redir_pc_i),
    .rd_tid_i    (tid_o),
    .pc_o        (pc_o)
  );
endmodule

// File: rtl/mt_issue_sel_chk.sv
module mt_issue_sel_chk #(
  parameter int  NUM_THREADS = 4,
  localparam int TID_W       = $clog2(NUM_THREADS)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   mode_i,
  input logic [NUM_THREADS-1:0] ready_i,
  input logic [NUM_THREADS-1:0] stall_i,
  input logic                   miss_i,
  input logic [TID_W-1:0]       tid_o,
  input logic                   issue_o,
  input logic                   switch_o
);
  // R3
  issue_eligible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |-> (ready_i[tid_o] && !stall_i[tid_o]));

  // R4
  no_ready_no_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ready_i & ~stall_i) == '0) |-> !issue_o);

  // R5
  coarse_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && $past(mode_i) && !$past(switch_o)) |-> (tid_o == $past(tid_o)));

  // R7
  bubble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && switch_o) |=> !issue_o);

  // R8
  park_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && miss_i) |=> !(issue_o && tid_o == $past(tid_o)));
endmodule

bind mt_issue_sel mt_issue_sel_chk #(.NUM_THREADS(NUM_THREADS)) u_chk (.*);

// File: tb/sim_mt_issue_sel.sv
module sim_mt_issue_sel;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode_i = 1'b0;
  logic [3:0]  ready_i = '0, stall_i = '0, miss_done_i = '0;
  logic        miss_i = 1'b0, adv_i = 1'b0, redir_i = 1'b0;
  logic [1:0]  redir_tid_i = '0;
  logic [31:0] redir_pc_i = '0;
  logic [1:0]  tid_o;
  logic        issue_o, switch_o;
  logic [31:0] pc_o;
  int total = 0, bad = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  mt_issue_sel #(.NUM_THREADS(NT)) u0 (.*);

  // {ready, stall, exp_issue, exp_tid, exp_switch}, fine mode, from reset
  localparam logic [11:0] VEC [10] = '{
    {4'hF, 4'h0, 1'b1, 2'd0, 1'b0},
    {4'hF, 4'h0, 1'b1, 2'd1, 1'b1},
    {4'hF, 4'h4, 1'b1, 2'd3, 1'b1},
    {4'hF, 4'h0, 1'b1, 2'd0, 1'b1},
    {4'h0, 4'h0, 1'b0, 2'd0, 1'b0},
    {4'h8, 4'h0, 1'b1, 2'd3, 1'b1},
    {4'h8, 4'h0, 1'b1, 2'd3, 1'b0},
    {4'h5, 4'h0, 1'b1, 2'd0, 1'b1},
    {4'h5, 4'h0, 1'b1, 2'd2, 1'b1},
    {4'hF, 4'hF, 1'b0, 2'd2, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic m, input logic [3:0] rdy, input logic [3:0] stl,
                       input logic ms, input logic [3:0] dn, input logic ad);
    @(negedge clk_i);
    mode_i = m; ready_i = rdy; stall_i = stl; miss_i = ms; miss_done_i = dn; adv_i = ad;
    redir_i = 1'b0;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; miss_i = 0; miss_done_i = '0; adv_i = 0; redir_i = 0;
    ready_i = '0; stall_i = '0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic exp3(input string req, input logic i, input logic [1:0] t, input logic s);
    chk(req, {31'd0, issue_o}, {31'd0, i});
    chk(req, {30'd0, tid_o}, {30'd0, t});
    chk(req, {31'd0, switch_o}, {31'd0, s});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1: coarse from reset sits on thread 0 with BOOT_PC
    drive(1'b1, 4'hF, 4'h0, 1'b0, 4'h0, 1'b0);
    exp3("R1", 1'b1, 2'd0, 1'b0);
    chk("R1", pc_o, 32'h0);

    // fine-grain vector table (R2, R3, R4)
    do_reset();
    for (int v = 0; v < 10; v++) begin
      drive(1'b0, VEC[v][11:8], VEC[v][7:4], 1'b0, 4'h0, 1'b0);
      chk(VEC[v][3] ? "R2" : "R4", {31'd0, issue_o}, {31'd0, VEC[v][3]});
      chk(VEC[v][7:4] != 0 ? "R3" : "R2", {30'd0, tid_o}, {30'd0, VEC[v][2:1]});
      chk("R2", {31'd0, switch_o}, {31'd0, VEC[v][0]});
    end

    // R8: fine-grain park and release
    do_reset();
    drive(1'b0, 4'hF, 4'h0, 1'b1, 4'h0, 1'b0);
    exp3("R8", 1'b1, 2'd0, 1'b0);
    drive(1'b0, 4'hF, 4'h0, 1'b0, 4'h0, 1'b0);
    drive(1'b0, 4'hF, 4'h0, 1'b0, 4'h0, 1'b0);
    drive(1'b0, 4'hF, 4'h0, 1'b0, 4'h0, 1'b0);
    exp3("R8", 1'b1, 2'd3, 1'b1);
    drive(1'b0, 4'hF, 4'h0, 1'b0, 4'h1, 1'b0);
    exp3("R8", 1'b1, 2'd1, 1'b1);
    drive(1'b0, 4'hF, 4'h0, 1'b0, 4'h0, 1'b0);
    drive(1'b0, 4'hF, 4'h0, 1'b0, 4'h0, 1'b0);
    drive(1'b0, 4'hF, 4'h0, 1'b0, 4'h0, 1'b0);
    exp3("R8", 1'b1, 2'd0, 1'b1);

    // coarse-grain sequence
    do_reset();
    drive(1'b1, 4'hF, 4'h0, 1'b0, 4'h0, 1'b0);
    drive(1'b1, 4'hF, 4'h0, 1'b0, 4'h0, 1'b0);
    exp3("R5", 1'b1, 2'd0, 1'b0);
    drive(1'b1, 4'hF, 4'h1, 1'b0, 4'h0, 1'b0);
    exp3("R5", 1'b0, 2'd0, 1'b0);
    drive(1'b1, 4'hF, 4'h0, 1'b1, 4'h0, 1'b0);
    exp3("R6", 1'b1, 2'd0, 1'b1);
    drive(1'b1, 4'hF, 4'h0, 1'b0, 4'h0, 1'b0);
    exp3("R7", 1'b0, 2'd1, 1'b0);
    drive(1'b1, 4'hF, 4'h0, 1'b0, 4'h0, 1'b0);
    exp3("R7", 1'b0, 2'd1, 1'b0);
    drive(1'b1, 4'hF, 4'h0, 1'b0, 4'h0, 1'b0);
    exp3("R7", 1'b1, 2'd1, 1'b0);
    drive(1'b1, 4'hF, 4'h0, 1'b1, 4'h0, 1'b0);
    exp3("R6", 1'b1, 2'd1, 1'b1);
    drive(1'b1, 4'hF, 4'h0, 1'b0, 4'h0, 1'b0);
    drive(1'b1, 4'hF, 4'h0, 1'b0, 4'h0, 1'b0);
    drive(1'b1, 4'hF, 4'h0, 1'b1, 4'h0, 1'b0);
    exp3("R6", 1'b1, 2'd2, 1'b1);
    drive(1'b1, 4'hF, 4'h0, 1'b0, 4'h0, 1'b0);
    drive(1'b1, 4'hF, 4'h0, 1'b0, 4'h0, 1'b0);
    drive(1'b1, 4'hF, 4'h0, 1'b1, 4'h0, 1'b0);
    exp3("R9", 1'b1, 2'd3, 1'b0);
    drive(1'b1, 4'hF, 4'h0, 1'b0, 4'h0, 1'b0);
    exp3("R9", 1'b0, 2'd3, 1'b0);
    drive(1'b1, 4'hF, 4'h0, 1'b0, 4'h1, 1'b0);
    exp3("R8", 1'b0, 2'd3, 1'b1);
    drive(1'b1, 4'hF, 4'h0, 1'b0, 4'h0, 1'b0);
    drive(1'b1, 4'hF, 4'h0, 1'b0, 4'h0, 1'b0);
    exp3("R7", 1'b0, 2'd0, 1'b0);
    drive(1'b1, 4'hF, 4'h0, 1'b0, 4'h0, 1'b0);
    exp3("R8", 1'b1, 2'd0, 1'b0);

    // program counters (R10, R11)
    do_reset();
    drive(1'b1, 4'hF, 4'h0, 1'b0, 4'h0, 1'b1);
    chk("R10", pc_o, 32'h0);
    drive(1'b1, 4'hF, 4'h0, 1'b0, 4'h0, 1'b1);
    chk("R10", pc_o, 32'h4);
    drive(1'b1, 4'hF, 4'h0, 1'b0, 4'h0, 1'b0);
    chk("R10", pc_o, 32'h8);
    drive(1'b1, 4'hF, 4'h1, 1'b0, 4'h0, 1'b1);
    chk("R10", pc_o, 32'h8);
    drive(1'b1, 4'hF, 4'h0, 1'b0, 4'h0, 1'b1);
    redir_i = 1'b1; redir_tid_i = 2'd0; redir_pc_i = 32'h80;
    chk("R10", pc_o, 32'h8);
    drive(1'b1, 4'hF, 4'h0, 1'b0, 4'h0, 1'b0);
    chk("R11", pc_o, 32'h80);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule